// File: doc/BRIEF.md
# Serial ADC Interface Controller

This block is the converter-side digital controller of a three-wire serial analog-to-digital converter. A host drives an active-low select, an optional frame-sync strobe and a serial clock. The controller counts serial clock falling edges inside each frame and opens a twelve-period sample window. When the frame ends it starts a conversion of fixed length. During the frame it shifts the result of the previous conversion out, most significant bit first, on a data line that has an output enable. All host pins are sampled on the system clock. The conversion time is a count of system clock cycles and stands in for an internal oscillator. The analog front end is abstracted as a 12-bit code input. The controller captures that code when the sample window closes and moves it into the result register when the conversion completes.

The block drives a two-input channel select. The select alternates on every rising edge of the select line, so successive frames sample alternate inputs. A rising edge of the select line while a conversion is still running abandons that conversion. Once the converter has no conversion running it reports a power-down state, and it leaves that state when a new frame or a new conversion begins.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the output enable is 0, the channel select is 0, busy is 0, power-down is 1 and the result register is zero, so the first frame shifts out sixteen zero bits.
- R2: A frame has FRAME_BITS (16) bits, sent most significant bit first. Frame bits 15..4 carry the 12-bit result, bit 15 being result bit 11, and frame bits 3..0 are always 0.
- R3: The output enable rises when the select line falls, with the first frame bit already on the data line. It falls after the 16th counted serial clock falling edge, and it also falls when the select line rises. The data line changes only on counted serial clock falling edges.
- R4: sample_o is 1 from the 4th counted serial clock falling edge up to the 16th, which makes it 1 for exactly 12 serial clock periods. It is 0 at every other time.
- R5: The 16th counted falling edge starts a conversion and captures code_i. busy_o is then 1 for exactly CONV_CYCLES system clock cycles.
- R6: The data shifted out in a frame is the result of the last conversion that completed, which is the one sampled in the previous frame.
- R7: A rising edge of the select line while busy_o is 1 ends the conversion in the next cycle and leaves the result register unchanged.
- R8: If the select line rises in the same cycle in which a conversion completes, the conversion completes and the result register is updated.
- R9: The channel select inverts on every rising edge of the select line and holds its value at all other times.
- R10: If fs_i is 0 when the select line falls, serial clock edges are ignored until a rising edge of fs_i. Each such rising edge, while the select line stays low, reloads the frame starting at the first bit. If fs_i is 1 when the select line falls, the frame starts at that falling edge.
- R11: power-down is set when a conversion completes or is abandoned. It is cleared by a falling edge of the select line or by the start of a conversion, and it is never 1 while busy_o is 1.
- R12: A rising edge of the select line before the 16th falling edge abandons the frame: no conversion starts and the result register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also times the conversion |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select from the host |
| fs_i | input | 1 | Frame-sync strobe; a rising edge starts a frame in frame-sync mode |
| sclk_i | input | 1 | Serial clock from the host |
| code_i | input | RES_W | Code presented by the abstracted analog front end |
| sdo_o | output | 1 | Serial data, valid while sdo_oe_o is 1 |
| sdo_oe_o | output | 1 | Output enable of the serial data line (0 = high impedance) |
| sample_o | output | 1 | Sample window strobe to the front end |
| chan_o | output | 1 | Input channel select |
| busy_o | output | 1 | Conversion in progress |
| pwr_dn_o | output | 1 | Converter powered down |

## Verification
Two events can fall in the same system clock cycle: the last cycle of a running conversion and a rising edge of the select line that would abandon it. The bench counts cycles from the 16th falling edge and raises the select line so that the design registers the rising edge on exactly the clock edge where the conversion timer expires. It then checks that the next frame carries the new code, which shows that completion won over abandonment. A second run raises the select line a few cycles into the conversion and expects the older result to come back in the next frame.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  localparam int unsigned DEF_RES_W        = 12;
  localparam int unsigned DEF_FRAME_BITS   = 16;
  localparam int unsigned DEF_SAMPLE_START = 4;
  localparam int unsigned DEF_CONV_CYCLES  = 438;  // 3.5 us at 125 MHz

  typedef struct packed {
    logic load;     // frame (re)start: load shifter, enable output
    logic shift;    // counted sclk falling edge
    logic last;     // final counted edge of the frame
    logic cs_fall;
    logic cs_rise;
  } seq_ev_t;
endpackage

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_serial_pkg::*;
#(
  parameter int unsigned FRAME_BITS   = DEF_FRAME_BITS,
  parameter int unsigned SAMPLE_START = DEF_SAMPLE_START
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_ni,
  input  logic    fs_i,
  input  logic    sclk_i,
  output seq_ev_t ev_o,
  output logic    sample_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_SAMPL = CNT_W'(SAMPLE_START);

  logic cs_q, fs_q, sclk_q;
  logic sel_q, fs_mode_q, run_q;
  logic [CNT_W-1:0] cnt_q;
  logic cs_fall, cs_rise, fs_rise, sclk_fall, fs_load, shift, last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      fs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      fs_q   <= fs_i;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall   = cs_q & ~cs_ni;
  assign cs_rise   = ~cs_q & cs_ni;
  assign fs_rise   = ~fs_q & fs_i;
  assign sclk_fall = sclk_q & ~sclk_i;
  assign fs_load   = fs_rise & sel_q & fs_mode_q & ~cs_rise;
  assign shift     = sclk_fall & run_q & ~cs_rise & ~fs_load;
  assign last      = shift & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      fs_mode_q <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
    end else if (cs_fall) begin
      sel_q     <= 1'b1;
      fs_mode_q <= ~fs_i;   // strobe low at select fall: wait for its rise
      run_q     <= fs_i;
      cnt_q     <= '0;
    end else if (cs_rise) begin
      sel_q     <= 1'b0;
      fs_mode_q <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
    end else if (fs_load) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (shift) begin
      if (last) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sample_o      = run_q && (cnt_q >= CNT_SAMPL);
  assign ev_o.load     = cs_fall | fs_load;
  assign ev_o.shift    = shift;
  assign ev_o.last     = last;
  assign ev_o.cs_fall  = cs_fall;
  assign ev_o.cs_rise  = cs_rise;
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_serial_pkg::*;
#(
  parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
  parameter int unsigned RES_W      = DEF_RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_ev_t          ev_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             oe_o
);
  localparam int unsigned PAD_W = FRAME_BITS - RES_W;

  logic [FRAME_BITS-1:0] sh_q;
  logic                  oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (ev_i.load) begin
      sh_q <= {result_i, {PAD_W{1'b0}}};
      oe_q <= 1'b1;
    end else begin
      if (ev_i.shift) sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
      if (ev_i.last || ev_i.cs_rise) oe_q <= 1'b0;
    end
  end

  assign sdo_o = oe_q & sh_q[FRAME_BITS-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model
  import adc_serial_pkg::*;
#(
  parameter int unsigned RES_W       = DEF_RES_W,
  parameter int unsigned CONV_CYCLES = DEF_CONV_CYCLES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             wake_i,
  input  logic [RES_W-1:0] code_i,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             pwr_dn_o
);
  localparam int unsigned TMR_W = $clog2(CONV_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_INIT = TMR_W'(CONV_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic [RES_W-1:0] hold_q, res_q;
  logic             busy_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      hold_q <= '0;
      res_q  <= '0;
      busy_q <= 1'b0;
      pd_q   <= 1'b1;
    end else if (start_i) begin
      hold_q <= code_i;
      tmr_q  <= TMR_INIT;
      busy_q <= 1'b1;
      pd_q   <= 1'b0;
    end else if (busy_q) begin
      if (tmr_q == '0) begin        // completion outranks a same-cycle abort
        res_q  <= hold_q;
        busy_q <= 1'b0;
        pd_q   <= 1'b1;
      end else if (abort_i) begin
        busy_q <= 1'b0;
        pd_q   <= 1'b1;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else if (wake_i) begin
      pd_q <= 1'b0;
    end
  end

  assign result_o = res_q;
  assign busy_o   = busy_q;
  assign pwr_dn_o = pd_q;
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_serial_pkg::*;
#(
  parameter int unsigned RES_W        = DEF_RES_W,
  parameter int unsigned FRAME_BITS   = DEF_FRAME_BITS,
  parameter int unsigned SAMPLE_START = DEF_SAMPLE_START,
  parameter int unsigned CONV_CYCLES  = DEF_CONV_CYCLES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             fs_i,
  input  logic             sclk_i,
  input  logic [RES_W-1:0] code_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             sample_o,
  output logic             chan_o,
  output logic             busy_o,
  output logic             pwr_dn_o
);
  seq_ev_t          ev;
  logic [RES_W-1:0] result;
  logic             chan_q;

  adc_frame_seq #(
    .FRAME_BITS  (FRAME_BITS),
    .SAMPLE_START(SAMPLE_START)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .fs_i    (fs_i),
    .sclk_i  (sclk_i),
    .ev_o    (ev),
    .sample_o(sample_o)
  );

  adc_shift_out #(
    .FRAME_BITS(FRAME_BITS),
    .RES_W     (RES_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .result_i(result),
    .sdo_o   (sdo_o),
    .oe_o    (sdo_oe_o)
  );

  adc_conv_model #(
    .RES_W      (RES_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ev.last),
    .abort_i (ev.cs_rise),
    .wake_i  (ev.cs_fall),
    .code_i  (code_i),
    .result_o(result),
    .busy_o  (busy_o),
    .pwr_dn_o(pwr_dn_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chan_q <= 1'b0;
    else if (ev.cs_rise) chan_q <= ~chan_q;
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_oe_o,
  input logic sample_o,
  input logic chan_o,
  input logic busy_o,
  input logic pwr_dn_o
);
  AST_OE_OFF_ON_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> !sdo_oe_o); // R3

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !$past(cs_ni)); // R3

  AST_NO_SAMPLE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !sample_o); // R4

  AST_ABORT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> !busy_o); // R7

  AST_CHAN_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |=> (chan_o != $past(chan_o))); // R9

  AST_CHAN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cs_ni) |=> $stable(chan_o)); // R9

  AST_PD_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> pwr_dn_o); // R11

  AST_NO_PD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !pwr_dn_o); // R11
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .sdo_oe_o(sdo_oe_o),
  .sample_o(sample_o),
  .chan_o  (chan_o),
  .busy_o  (busy_o),
  .pwr_dn_o(pwr_dn_o)
);

// File: tb/adc_serial_ctrl_test.sv
module adc_serial_ctrl_test;
  localparam int CONV = 438;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        fs_i = 1'b1;
  logic        sclk_i = 1'b0;
  logic [11:0] code_i = '0;
  logic        sdo_o, sdo_oe_o, sample_o, chan_o, busy_o, pwr_dn_o;

  int n_chk = 0;
  int n_err = 0;
  logic [11:0] exp_res = '0;
  logic        exp_chan = 1'b0;

  always #4 clk = ~clk;

  adc_serial_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .fs_i(fs_i), .sclk_i(sclk_i),
    .code_i(code_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .sample_o(sample_o),
    .chan_o(chan_o), .busy_o(busy_o), .pwr_dn_o(pwr_dn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // n serial clock pulses; the bit is read before each falling edge, sample_o after it
  task automatic do_bits(input int n, input bit in_frame, output logic [15:0] got,
                         output int samp_bad);
    got = '0;
    samp_bad = 0;
    for (int i = 0; i < n; i++) begin
      got[15-i] = sdo_o;
      sclk_i = 1'b1;
      repeat (2) @(negedge clk);
      sclk_i = 1'b0;
      @(negedge clk);
      if (sample_o !== (in_frame && (i + 1) >= 4 && (i + 1) <= 15)) samp_bad++;
    end
  endtask

  task automatic deselect();
    cs_ni = 1'b1;
    @(negedge clk);
    exp_chan = ~exp_chan;
    chk(sdo_oe_o == 1'b0, "R3 oe off at deselect", sdo_oe_o, 0);
    chk(chan_o == exp_chan, "R9 channel toggles", chan_o, exp_chan);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_conv(input string req);
    int n = 0;
    while (busy_o && n < CONV + 10) begin
      n++;
      @(negedge clk);
    end
    chk(n == CONV, req, n, CONV);
    chk(pwr_dn_o == 1'b1, "R11 power-down after completion", pwr_dn_o, 1);
  endtask

  // frame started by the select line; runs to the 16th edge
  task automatic run_frame(input logic [11:0] code);
    logic [15:0] got;
    int sb;
    code_i = code;
    fs_i = 1'b1;
    cs_ni = 1'b0;
    @(negedge clk);
    chk(sdo_oe_o == 1'b1 && sdo_o == exp_res[11], "R3 MSB on select fall",
        {sdo_oe_o, sdo_o}, {1'b1, exp_res[11]});
    chk(pwr_dn_o == 1'b0, "R11 wake on select fall", pwr_dn_o, 0);
    do_bits(16, 1'b1, got, sb);
    chk(got == {exp_res, 4'h0}, "R2 R6 frame content", got, {exp_res, 4'h0});
    chk(sb == 0, "R4 sample window", sb, 0);
    chk(sdo_oe_o == 1'b0 && busy_o == 1'b1, "R3 R5 oe off, busy on after 16th edge",
        {sdo_oe_o, busy_o}, 2'b01);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    logic [11:0] codes [22];
    int sb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sdo_oe_o == 0 && chan_o == 0 && busy_o == 0 && pwr_dn_o == 1, "R1 reset outputs",
        {sdo_oe_o, chan_o, busy_o, pwr_dn_o}, 4'b0001);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_oe_o == 0 && sample_o == 0, "R1 idle after reset", {sdo_oe_o, sample_o}, 0);

    // sweep: single-bit codes, extremes and a spread
    for (int k = 0; k < 12; k++) codes[k] = 12'(1 << k);
    codes[12] = 12'hFFF;
    codes[13] = 12'h000;
    for (int k = 14; k < 22; k++) codes[k] = 12'((k * 16'h3A7) & 16'hFFF);
    for (int k = 0; k < 22; k++) begin
      run_frame(codes[k]);
      wait_conv("R5 conversion length");
      exp_res = codes[k];
      deselect();
    end

    // R7 abort during conversion
    run_frame(12'h123);
    repeat (10) @(negedge clk);
    cs_ni = 1'b1;
    @(negedge clk);
    exp_chan = ~exp_chan;
    chk(busy_o == 0 && pwr_dn_o == 1, "R7 R11 abort ends busy", {busy_o, pwr_dn_o}, 2'b01);
    repeat (2) @(negedge clk);
    run_frame(12'hB6D);            // R7: previous result still out
    // R8 completion in the same cycle as deselect
    repeat (CONV - 1) @(negedge clk);
    cs_ni = 1'b1;
    @(negedge clk);
    exp_chan = ~exp_chan;
    exp_res = 12'hB6D;
    chk(busy_o == 0 && chan_o == exp_chan, "R8 R9 same-cycle deselect", {busy_o, chan_o},
        {1'b0, exp_chan});
    repeat (2) @(negedge clk);
    run_frame(12'h4C1);            // checks R8 content
    wait_conv("R5 conversion length");
    exp_res = 12'h4C1;
    deselect();

    // R12 deselect mid-frame
    code_i = 12'h777;
    cs_ni = 1'b0;
    @(negedge clk);
    do_bits(8, 1'b1, got, sb);
    chk(got[15:8] == {exp_res, 4'h0} >> 8, "R12 partial frame bits", got[15:8],
        {exp_res, 4'h0} >> 8);
    deselect();
    repeat (20) @(negedge clk);
    chk(busy_o == 0, "R12 no conversion after abandoned frame", busy_o, 0);
    run_frame(12'h39C);            // R12: result unchanged
    wait_conv("R5 conversion length");
    exp_res = 12'h39C;
    deselect();

    // R10 frame-sync mode
    code_i = 12'hE18;
    fs_i = 1'b0;
    cs_ni = 1'b0;
    @(negedge clk);
    chk(sdo_oe_o == 1 && sdo_o == exp_res[11], "R10 R3 MSB on select fall, fs mode",
        {sdo_oe_o, sdo_o}, {1'b1, exp_res[11]});
    do_bits(3, 1'b0, got, sb);
    chk(sb == 0 && busy_o == 0, "R10 edges ignored before fs rise", sb, 0);
    fs_i = 1'b1;
    @(negedge clk);
    fs_i = 1'b0;
    do_bits(16, 1'b1, got, sb);
    chk(got == {exp_res, 4'h0}, "R10 frame after fs rise", got, {exp_res, 4'h0});
    chk(sb == 0, "R10 R4 sample window in fs mode", sb, 0);
    wait_conv("R5 conversion length fs mode");
    exp_res = 12'hE18;
    code_i = 12'h2A5;
    fs_i = 1'b1;                   // second frame, select held low
    @(negedge clk);
    fs_i = 1'b0;
    chk(sdo_oe_o == 1 && sdo_o == exp_res[11], "R10 reload on fs rise", {sdo_oe_o, sdo_o},
        {1'b1, exp_res[11]});
    do_bits(16, 1'b1, got, sb);
    chk(got == {exp_res, 4'h0}, "R10 R6 second fs frame", got, {exp_res, 4'h0});
    chk(busy_o == 1 && pwr_dn_o == 0, "R11 start clears power-down", {busy_o, pwr_dn_o}, 2'b10);
    wait_conv("R5 conversion length fs mode");
    exp_res = 12'h2A5;
    fs_i = 1'b1;
    deselect();
    run_frame(12'h000);
    chk(1'b1, "R6 final frame", 0, 0);
    wait_conv("R5 conversion length");
    deselect();

    disable watchdog;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule